// File: doc/BRIEF.md
# Rotating Priority Bus Arbiter

This block decides which requester owns a single shared external bus. Up to eight processor agents and one host compete for it. Each agent presents a request line and two urgency flags. One flag marks a core-initiated access and the other marks a DMA transfer raised to high priority. Each agent also presents a strobe that marks the last cycle of its current transaction. The host has one request line. The arbiter drives a one-hot agent grant, a separate host grant, and the identity of the agent that most recently held the bus.

Requests fall into four urgency classes. The host is the most urgent. Below it, in order, are a request with the core flag set, a request with the DMA flag set, and a plain request. Within any class the bus passes in rotation. The search starts one identity above the agent recorded as master, counts upward and wraps to zero. An owner keeps the bus for as long as it requests it, unless a more urgent class is waiting. Even then, the bus changes hands only at the end of the owner's transaction. The recorded master identity is the starting point of the rotation, and it stays in place while the bus sits idle.

Top module: `bus_rotary_arbiter`

## Requirements
- R1: While reset is applied, agent 0 owns the bus: grant is 0001, host_grant is 0 and master_id is 0.
- R2: grant has at most one bit set, agent and host grants are never high together, and when an agent is granted, master_id is the index of the set grant bit.
- R3: When the bus is free to change hands within a class, the winner is the first requester of that class found by counting upward from master_id+1, wrapping past the highest agent back to 0, with master_id itself examined last.
- R4: Class order from most to least urgent is host_req; agt_req with agt_core; agt_req with agt_dmahi and not agt_core; agt_req alone. agt_core outranks agt_dmahi on the same agent, and neither flag has any effect while that agent's agt_req is low.
- R5: An owning agent whose request stays high keeps the bus through its done strobe whenever no request of a strictly more urgent class exists, even if other agents of its own class are waiting.
- R6: A more urgent request takes the bus from an owning agent only at the clock edge that samples agt_done high on that owner. A done strobe from any other agent does not move the bus.
- R7: Among several agents requesting with agt_core, the R3 rotation picks the winner, not the lowest identity.
- R8: When a core-class owner releases and no core request remains, a plain-class agent that lost the bus to it and still requests gets it back.
- R9: With no agent and no host requesting, both grants go to zero on the next edge and master_id keeps its last value.
- R10: The host keeps the bus while host_req stays high, regardless of agent activity; master_id is unchanged while the host holds it.
- R11: An owner that lowers its request loses the grant at the next clock edge, and the bus is re-arbitrated among the remaining requests in that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| agt_req | input | N_AGENTS | Bus request per agent |
| agt_core | input | N_AGENTS | Core-access urgency flag per agent |
| agt_dmahi | input | N_AGENTS | High-priority DMA urgency flag per agent |
| agt_done | input | N_AGENTS | Last cycle of the current transaction, per agent |
| host_req | input | 1 | Host bus request |
| grant | output | N_AGENTS | One-hot agent grant |
| host_grant | output | 1 | Host grant |
| master_id | output | ID_W | Identity of the current or most recent agent master |

## Verification
The hard case is an owner's done strobe arriving in the same cycle as a waiting request from a more urgent class. The preemption path and the hold path then both want to decide the next owner. The bench sets up both conditions in one cycle in several forms: a plain owner against a core request, a plain owner against a core request that also carries the DMA flag, and a DMA owner against the host. It also sends a done strobe from an agent that does not own the bus, and sends done in a cycle where only same-class rivals wait. In each case it compares the grant, the host grant and the master identity one edge later against values derived from the class order and the rotation rule.

// File: rtl/rot_arb_pkg.sv
package rot_arb_pkg;

   // Urgency classes, ordered so that a larger value wins.
   typedef enum logic [2:0] {
      CLS_NONE  = 3'd0,
      CLS_PLAIN = 3'd1,
      CLS_DMA   = 3'd2,
      CLS_CORE  = 3'd3,
      CLS_HOST  = 3'd4
   } bus_cls_e;

   // Agent-side classes are carried as lanes of masks.
   localparam int CLS_LANES  = 3;
   localparam int LANE_CORE  = 0;
   localparam int LANE_DMA   = 1;
   localparam int LANE_PLAIN = 2;

   localparam int MIN_AGENTS = 2;
   localparam int MAX_AGENTS = 8;

endpackage

// File: rtl/rot_arb_class_split.sv
module rot_arb_class_split
   import rot_arb_pkg::*;
#(
   parameter int N = 4
) (
   input  logic [N-1:0]                 req,
   input  logic [N-1:0]                 core,
   input  logic [N-1:0]                 dmahi,
   output logic [CLS_LANES-1:0][N-1:0]  lane_mask
);

   // A flag only counts while its agent is requesting; core wins over dma.
   for (genvar i = 0; i < N; i++) begin : g_agent
      assign lane_mask[LANE_CORE][i]  = req[i] &  core[i];
      assign lane_mask[LANE_DMA][i]   = req[i] & ~core[i] &  dmahi[i];
      assign lane_mask[LANE_PLAIN][i] = req[i] & ~core[i] & ~dmahi[i];
   end

endmodule

// File: rtl/rot_arb_rr_pick.sv
module rot_arb_rr_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  mask,
   input  logic [IW-1:0] ref_id,
   output logic          hit,
   output logic [IW-1:0] win
);

   // Search ref+1, ref+2, ... wrapping, with ref itself visited last.
   logic [IW-1:0] cand [N];

   for (genvar k = 0; k < N; k++) begin : g_cand
      assign cand[k] = IW'((int'(ref_id) + k + 1) % N);
   end

   always_comb begin
      hit = 1'b0;
      win = ref_id;
      for (int k = 0; k < N; k++) begin
         if (!hit && mask[cand[k]]) begin
            hit = 1'b1;
            win = cand[k];
         end
      end
   end

endmodule

// File: rtl/rot_arb_owner_ctl.sv
module rot_arb_owner_ctl
   import rot_arb_pkg::*;
#(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          host_req,
   input  logic [N-1:0]                  agt_done,
   input  logic [CLS_LANES-1:0][N-1:0]   lane_mask,
   input  logic [CLS_LANES-1:0]          lane_hit,
   input  logic [CLS_LANES-1:0][IW-1:0]  lane_win,
   output logic [N-1:0]                  grant,
   output logic                          host_grant,
   output logic [IW-1:0]                 master_id
);

   logic          own_valid_q, own_host_q;
   logic [IW-1:0] own_id_q;
   logic          own_valid_d, own_host_d;
   logic [IW-1:0] own_id_d;

   bus_cls_e cur_cls, best_cls;
   logic     owner_done, take;

   // Class of the present owner, from live flags; NONE means released.
   always_comb begin
      if (!own_valid_q)                         cur_cls = CLS_NONE;
      else if (own_host_q)                      cur_cls = host_req ? CLS_HOST : CLS_NONE;
      else if (lane_mask[LANE_CORE][own_id_q])  cur_cls = CLS_CORE;
      else if (lane_mask[LANE_DMA][own_id_q])   cur_cls = CLS_DMA;
      else if (lane_mask[LANE_PLAIN][own_id_q]) cur_cls = CLS_PLAIN;
      else                                      cur_cls = CLS_NONE;
   end

   // Most urgent class with any pending request.
   always_comb begin
      if (host_req)                  best_cls = CLS_HOST;
      else if (lane_hit[LANE_CORE])  best_cls = CLS_CORE;
      else if (lane_hit[LANE_DMA])   best_cls = CLS_DMA;
      else if (lane_hit[LANE_PLAIN]) best_cls = CLS_PLAIN;
      else                           best_cls = CLS_NONE;
   end

   assign owner_done = own_valid_q & ~own_host_q & agt_done[own_id_q];
   assign take       = (cur_cls == CLS_NONE) ||
                       (owner_done && (best_cls > cur_cls));

   always_comb begin
      own_valid_d = own_valid_q;
      own_host_d  = own_host_q;
      own_id_d    = own_id_q;
      if (take) begin
         unique case (best_cls)
            CLS_HOST: begin
               own_valid_d = 1'b1;
               own_host_d  = 1'b1;
            end
            CLS_CORE: begin
               own_valid_d = 1'b1;
               own_host_d  = 1'b0;
               own_id_d    = lane_win[LANE_CORE];
            end
            CLS_DMA: begin
               own_valid_d = 1'b1;
               own_host_d  = 1'b0;
               own_id_d    = lane_win[LANE_DMA];
            end
            CLS_PLAIN: begin
               own_valid_d = 1'b1;
               own_host_d  = 1'b0;
               own_id_d    = lane_win[LANE_PLAIN];
            end
            default: begin
               own_valid_d = 1'b0;
               own_host_d  = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_valid_q <= 1'b1;
         own_host_q  <= 1'b0;
         own_id_q    <= '0;
      end else begin
         own_valid_q <= own_valid_d;
         own_host_q  <= own_host_d;
         own_id_q    <= own_id_d;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_grant
      assign grant[i] = own_valid_q & ~own_host_q & (own_id_q == IW'(i));
   end

   assign host_grant = own_valid_q & own_host_q;
   assign master_id  = own_id_q;

endmodule

// File: rtl/bus_rotary_arbiter.sv
module bus_rotary_arbiter
   import rot_arb_pkg::*;
#(
   parameter int N_AGENTS = 4,
   localparam int ID_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_AGENTS-1:0] agt_req,
   input  logic [N_AGENTS-1:0] agt_core,
   input  logic [N_AGENTS-1:0] agt_dmahi,
   input  logic [N_AGENTS-1:0] agt_done,
   input  logic                host_req,
   output logic [N_AGENTS-1:0] grant,
   output logic                host_grant,
   output logic [ID_W-1:0]     master_id
);

   if (N_AGENTS < MIN_AGENTS || N_AGENTS > MAX_AGENTS) begin : g_bad_count
      $error("bus_rotary_arbiter: N_AGENTS must lie in 2..8");
   end

   logic [CLS_LANES-1:0][N_AGENTS-1:0] lane_mask;
   logic [CLS_LANES-1:0]               lane_hit;
   logic [CLS_LANES-1:0][ID_W-1:0]     lane_win;

   rot_arb_class_split #(.N(N_AGENTS)) u_split (
      .req       (agt_req),
      .core      (agt_core),
      .dmahi     (agt_dmahi),
      .lane_mask (lane_mask)
   );

   for (genvar l = 0; l < CLS_LANES; l++) begin : g_lane
      rot_arb_rr_pick #(.N(N_AGENTS), .IW(ID_W)) u_pick (
         .mask   (lane_mask[l]),
         .ref_id (master_id),
         .hit    (lane_hit[l]),
         .win    (lane_win[l])
      );
   end

   rot_arb_owner_ctl #(.N(N_AGENTS), .IW(ID_W)) u_owner (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_req   (host_req),
      .agt_done   (agt_done),
      .lane_mask  (lane_mask),
      .lane_hit   (lane_hit),
      .lane_win   (lane_win),
      .grant      (grant),
      .host_grant (host_grant),
      .master_id  (master_id)
   );

endmodule

// File: rtl/bus_rotary_arbiter_chk.sv
module bus_rotary_arbiter_chk #(
   parameter int N_AGENTS = 4,
   parameter int ID_W     = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [N_AGENTS-1:0] agt_req,
   input logic [N_AGENTS-1:0] agt_done,
   input logic                host_req,
   input logic [N_AGENTS-1:0] grant,
   input logic                host_grant,
   input logic [ID_W-1:0]     master_id
);

   logic seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   p_grant_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && !(host_grant && (grant != '0)));

   p_id_matches_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |-> (grant == (N_AGENTS'(1) << master_id)));

   p_hold_until_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (((grant & agt_req) != '0) && ((grant & agt_done) == '0))
      |=> ($stable(grant) && !host_grant));

   p_host_preempts_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (((grant & agt_done) != '0) && host_req) |=> host_grant);

   p_host_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_grant && host_req) |=> (host_grant && $stable(master_id)));

   p_idle_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_req && (agt_req == '0)) |=> ((grant == '0) && !host_grant && $stable(master_id)));

   p_grant_follows_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && (grant != '0)) |-> (($past(agt_req) & grant) != '0));

endmodule

bind bus_rotary_arbiter bus_rotary_arbiter_chk #(.N_AGENTS(N_AGENTS), .ID_W(ID_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .agt_req    (agt_req),
   .agt_done   (agt_done),
   .host_req   (host_req),
   .grant      (grant),
   .host_grant (host_grant),
   .master_id  (master_id)
);

// File: tb/bus_rotary_arbiter_bench.sv
module bus_rotary_arbiter_bench;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] agt_req = '0, agt_core = '0, agt_dmahi = '0, agt_done = '0;
   logic         host_req = 1'b0;
   logic [N-1:0] grant;
   logic         host_grant;
   logic [1:0]   master_id;

   int checks = 0;
   int fails  = 0;
   logic [6:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   bus_rotary_arbiter #(.N_AGENTS(N)) u_bus_rotary_arbiter (
      .clk(clk), .rst_n(rst_n), .agt_req(agt_req), .agt_core(agt_core),
      .agt_dmahi(agt_dmahi), .agt_done(agt_done), .host_req(host_req),
      .grant(grant), .host_grant(host_grant), .master_id(master_id)
   );

   task automatic compare(input logic [6:0] exp, input string tag);
      checks++;
      if ({grant, host_grant, master_id} !== exp) begin
         fails++;
         $display("FAIL %s: grant=%b host=%b id=%0d expected grant=%b host=%b id=%0d",
                  tag, grant, host_grant, master_id, exp[6:3], exp[2], exp[1:0]);
      end
   endtask

   // Monitor: compares each queued expectation mid-cycle.
   always @(negedge clk) begin
      if (exp_q.size() != 0) compare(exp_q.pop_front(), tag_q.pop_front());
   end

   // Driver: apply inputs, let one edge pass, queue the expected outputs.
   task automatic step(input logic [3:0] rq, input logic [3:0] co, input logic [3:0] dm,
                       input logic [3:0] dn, input logic hr,
                       input logic [3:0] eg, input logic eh, input logic [1:0] eid,
                       input string tag);
      @(negedge clk);
      agt_req = rq; agt_core = co; agt_dmahi = dm; agt_done = dn; host_req = hr;
      @(posedge clk);
      #1;
      exp_q.push_back({eg, eh, eid});
      tag_q.push_back(tag);
   endtask

   initial begin
      #(20 * 5000);
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare({4'b0001, 1'b0, 2'd0}, "R1 reset owner");
      rst_n = 1'b1;
      //    req      core     dma      done     host  grant   hg   id
      step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000, 1'b0, 2'd0, "R9 idle after reset");
      step(4'b0001, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0001, 1'b0, 2'd0, "R3 rotation reaches ref last");
      step(4'b1011, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0001, 1'b0, 2'd0, "R5 owner holds");
      step(4'b1011, 4'b0000, 4'b0000, 4'b0001, 1'b0, 4'b0001, 1'b0, 2'd0, "R5 holds through done");
      step(4'b1010, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0010, 1'b0, 2'd1, "R11 R3 release to next up");
      step(4'b1001, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b1000, 1'b0, 2'd3, "R3 skip idle agent");
      step(4'b0001, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0001, 1'b0, 2'd0, "R3 wrap to zero");
      step(4'b0111, 4'b0100, 4'b0000, 4'b0000, 1'b0, 4'b0001, 1'b0, 2'd0, "R6 core waits for done");
      step(4'b0111, 4'b0100, 4'b0000, 4'b0010, 1'b0, 4'b0001, 1'b0, 2'd0, "R6 foreign done ignored");
      step(4'b0111, 4'b0100, 4'b0000, 4'b0001, 1'b0, 4'b0100, 1'b0, 2'd2, "R6 core takes at done");
      step(4'b0111, 4'b0110, 4'b0000, 4'b0100, 1'b0, 4'b0100, 1'b0, 2'd2, "R5 same class no switch");
      step(4'b1011, 4'b1010, 4'b0000, 4'b0000, 1'b0, 4'b1000, 1'b0, 2'd3, "R7 core rotation order");
      step(4'b0011, 4'b0010, 4'b0000, 4'b0000, 1'b0, 4'b0010, 1'b0, 2'd1, "R7 remaining core agent");
      step(4'b0001, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0001, 1'b0, 2'd0, "R8 plain agent regains");
      step(4'b0001, 4'b1000, 4'b0100, 4'b0001, 1'b0, 4'b0001, 1'b0, 2'd0, "R4 flags without request ignored");
      step(4'b0111, 4'b0100, 4'b0110, 4'b0001, 1'b0, 4'b0100, 1'b0, 2'd2, "R4 core over dma");
      step(4'b0011, 4'b0000, 4'b0010, 4'b0000, 1'b0, 4'b0010, 1'b0, 2'd1, "R4 dma over plain");
      step(4'b0011, 4'b0000, 4'b0010, 4'b0000, 1'b1, 4'b0010, 1'b0, 2'd1, "R6 host waits for done");
      step(4'b0011, 4'b0000, 4'b0010, 4'b0010, 1'b1, 4'b0000, 1'b1, 2'd1, "R4 R2 host takes at done");
      step(4'b0011, 4'b0011, 4'b0000, 4'b0011, 1'b1, 4'b0000, 1'b1, 2'd1, "R10 host keeps bus");
      step(4'b0011, 4'b0001, 4'b0010, 4'b0000, 1'b0, 4'b0001, 1'b0, 2'd0, "R10 host release to core");
      step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000, 1'b0, 2'd0, "R9 idle");
      step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 4'b0000, 1'b1, 2'd0, "R10 host from idle");
      step(4'b0100, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0100, 1'b0, 2'd2, "R2 R11 agent after host");
      step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000, 1'b0, 2'd2, "R9 id kept when idle");
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule